// File: doc/BRIEF.md
# Banked Indirect Test-Register Access

This unit sits behind the register port of a management-interface PHY. The port is the one a management-frame decoder presents: a write strobe, a 5-bit register address, 16-bit write data, and a 16-bit read data bus. The unit owns three locations in that register map: a command register, a read-result register and a staging register. Through them, software reaches up to four hidden banks of thirty-two 16-bit test registers.

The hidden banks stay locked until software writes a fixed pattern to the command register. The pattern is four consecutive command writes that toggle the test-mode bit off, on, off, on. Once open, a single command word either copies the staging register into a hidden register or copies a hidden register into the read-result register. A command word with the test-mode bit clear, such as zero, closes access again.

Bank 2 is left unpopulated. It reads as zero and swallows writes.

Top module: `tstreg_bank_access`

## Requirements
- R1: After reset, the command, read-result and staging registers all read 0, and the banks are locked.
- R2: The banks open only after four consecutive command-register writes of 0x0000, 0x0400, 0x0000, 0x0400. Any other command value in between restarts the tracker; a 0x0000 restarts it at step one. Writes to other addresses do not disturb the tracker.
- R3: When open, a command word with bit 14 set, bit 15 clear and bit 10 set copies the staging register into the hidden register selected by bank bits 12:11 and index bits 4:0. The copy happens at the clock edge of that command write.
- R4: When open, a command word with bit 15 set, bit 14 clear and bit 10 set loads the hidden register selected by bits 12:11 and index bits 9:5 into the read-result register. The value is readable from the next cycle.
- R5: A 0x0000 command write locks the banks. While locked, the read-result address reads 0 and read or write commands have no effect. The read-result register keeps its last value and shows it again once the banks reopen.
- R6: A command word with both bit 15 and bit 14 set is ignored: it changes neither the read-result register nor any hidden register.
- R7: Bank 2 is absent. A read from it returns 0, a write to it is discarded, and writes to it leave other banks untouched.
- R8: The command register is at address 20 and reads back the last word written. The read-result register is at 21 and is read-only. The staging register is at 23 and is readable and writable at any time. Every other address reads 0 and ignores writes.
- R9: Banks 0, 1 and 3 hold separate contents at the same index, over the full index range 0 to 31.
- R10: While open, a nonzero command word with bit 10 clear locks the banks and is not executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |

## Verification
The bench builds the block with its default parameters: command at 20, read-result at 21, staging at 23, and population mask 4'b1011. With the mask, the empty bank 2 sits between live banks, so discarded writes can be shown not to leak into neighbours. Directed sequences cover broken and interleaved unlock patterns, index 31, both-bit commands and relock by a word lacking test mode. A seeded random mix of unlocks, commands and reads across all 32 addresses is then compared against a behavioural model.

// File: rtl/tstreg_pkg.sv
package tstreg_pkg;

    localparam int WORD_W    = 16;
    localparam int IDX_W     = 5;
    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int REGS      = 1 << IDX_W;

    // command word field positions
    localparam int RD_BIT    = 15;
    localparam int WR_BIT    = 14;
    localparam int BANK_LSB  = 11;
    localparam int TM_BIT    = 10;
    localparam int RIDX_LSB  = 5;
    localparam int WIDX_LSB  = 0;

    localparam logic [WORD_W-1:0] TM_ONLY = WORD_W'(1) << TM_BIT;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_Z1,
        LK_T1,
        LK_Z2,
        LK_OPEN
    } lock_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic              tm;
        logic [IDX_W-1:0]  ridx;
        logic [IDX_W-1:0]  widx;
    } cmd_t;

endpackage

// File: rtl/tstreg_unlock.sv
module tstreg_unlock
    import tstreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] ctrl_val,
    output logic              open
);

    lock_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            if (state_q == LK_OPEN) begin
                if (ctrl_val == '0)
                    state_d = LK_Z1;
                else if (!ctrl_val[TM_BIT])
                    state_d = LK_IDLE;
            end else if (ctrl_val == '0) begin
                state_d = (state_q == LK_T1) ? LK_Z2 : LK_Z1;
            end else if (ctrl_val == TM_ONLY) begin
                case (state_q)
                    LK_Z1:   state_d = LK_T1;
                    LK_Z2:   state_d = LK_OPEN;
                    default: state_d = LK_IDLE;
                endcase
            end else begin
                state_d = LK_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    assign open = (state_q == LK_OPEN);

    // R2
    open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(ctrl_we && ctrl_val == TM_ONLY));

    // R5
    zero_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_val == '0) |=> !open);

endmodule

// File: rtl/tstreg_cmd_decode.sv
module tstreg_cmd_decode (
    input  logic ctrl_we,
    input  logic open,
    input  logic rd_req,
    input  logic wr_req,
    input  logic tm,
    output logic fire_rd,
    output logic fire_wr
);

    logic valid;

    always_comb begin
        valid   = ctrl_we && open && tm && (rd_req ^ wr_req);
        fire_rd = valid && rd_req;
        fire_wr = valid && wr_req;
    end

endmodule

// File: rtl/tstreg_bank_store.sv
module tstreg_bank_store
    import tstreg_pkg::*;
#(
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BANK_W-1:0] rbank,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (BANK_PRESENT[b]) begin : g_live
            logic [WORD_W-1:0] cell_d [REGS];
            logic [WORD_W-1:0] cell_q [REGS];

            always_comb begin
                cell_d = cell_q;
                if (we && wbank == BANK_W'(b))
                    cell_d[widx] = wdata;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < REGS; i++) cell_q[i] <= '0;
                end else begin
                    cell_q <= cell_d;
                end
            end

            assign bank_rd[b] = cell_q[ridx];
        end else begin : g_hole
            assign bank_rd[b] = '0;
        end
    end

    assign rdata = bank_rd[rbank];

    // R7
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !BANK_PRESENT[rbank] |-> rdata == '0);

endmodule

// File: rtl/tstreg_bank_access.sv
module tstreg_bank_access
    import tstreg_pkg::*;
#(
    parameter logic [IDX_W-1:0]     CTRL_ADDR    = 5'd20,
    parameter logic [IDX_W-1:0]     RDAT_ADDR    = 5'd21,
    parameter logic [IDX_W-1:0]     WDAT_ADDR    = 5'd23,
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = 4'b1011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] rdval;
        logic [WORD_W-1:0] wdat;
    } regs_t;

    regs_t regs_d, regs_q;
    cmd_t  cmd;
    logic  ctrl_we, open, fire_rd, fire_wr;
    logic [WORD_W-1:0] arr_rd;

    assign ctrl_we = reg_we && (reg_addr == CTRL_ADDR);

    assign cmd = '{
        rd:   reg_wdata[RD_BIT],
        wr:   reg_wdata[WR_BIT],
        bank: reg_wdata[BANK_LSB +: BANK_W],
        tm:   reg_wdata[TM_BIT],
        ridx: reg_wdata[RIDX_LSB +: IDX_W],
        widx: reg_wdata[WIDX_LSB +: IDX_W]
    };

    tstreg_unlock i_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .ctrl_val (reg_wdata),
        .open     (open)
    );

    tstreg_cmd_decode i_decode (
        .ctrl_we (ctrl_we),
        .open    (open),
        .rd_req  (cmd.rd),
        .wr_req  (cmd.wr),
        .tm      (cmd.tm),
        .fire_rd (fire_rd),
        .fire_wr (fire_wr)
    );

    tstreg_bank_store #(
        .BANK_PRESENT (BANK_PRESENT)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fire_wr),
        .wbank (cmd.bank),
        .widx  (cmd.widx),
        .wdata (regs_q.wdat),
        .rbank (cmd.bank),
        .ridx  (cmd.ridx),
        .rdata (arr_rd)
    );

    always_comb begin
        regs_d = regs_q;
        if (ctrl_we)
            regs_d.ctrl = reg_wdata;
        if (reg_we && reg_addr == WDAT_ADDR)
            regs_d.wdat = reg_wdata;
        if (fire_rd)
            regs_d.rdval = arr_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (reg_addr == CTRL_ADDR)
            reg_rdata = regs_q.ctrl;
        else if (reg_addr == RDAT_ADDR)
            reg_rdata = open ? regs_q.rdval : '0;
        else if (reg_addr == WDAT_ADDR)
            reg_rdata = regs_q.wdat;
        else
            reg_rdata = '0;
    end

    // R4
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rd |=> regs_q.rdval == $past(arr_rd));

    // R6
    both_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && reg_wdata[RD_BIT] && reg_wdata[WR_BIT]) |=> $stable(regs_q.rdval));

    // R5
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && reg_addr == RDAT_ADDR) |-> reg_rdata == '0);

    // R10
    no_tm_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !reg_wdata[TM_BIT]) |=> !open);

endmodule

// File: tb/test_tstreg_bank_access.sv
`timescale 1ns/1ps
module test_tstreg_bank_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tstreg_bank_access i_tstreg_bank_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // behavioural model
    int          m_st = 0;          // 0 idle,1 z1,2 t1,3 z2,4 open
    logic [15:0] m_ctrl = '0, m_rdval = '0, m_wdat = '0;
    logic [15:0] m_mem [4][32];

    function automatic bit bank_live(input int b);
        return b != 2;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        if (a == 5'd20) return m_ctrl;
        if (a == 5'd21) return (m_st == 4) ? m_rdval : 16'h0;
        if (a == 5'd23) return m_wdat;
        return 16'h0;
    endfunction

    task automatic mdl_ctrl(input logic [15:0] v);
        int b = int'(v[12:11]);
        if (m_st == 4 && v[10] && (v[15] ^ v[14])) begin
            if (v[15]) m_rdval = bank_live(b) ? m_mem[b][v[9:5]] : 16'h0;
            else if (bank_live(b)) m_mem[b][v[4:0]] = m_wdat;
        end
        if (m_st == 4) begin
            if (v == 16'h0) m_st = 1;
            else if (!v[10]) m_st = 0;
        end else if (v == 16'h0) begin
            m_st = (m_st == 2) ? 3 : 1;
        end else if (v == 16'h0400) begin
            m_st = (m_st == 1) ? 2 : (m_st == 3) ? 4 : 0;
        end else begin
            m_st = 0;
        end
        m_ctrl = v;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 5'd20) mdl_ctrl(d);
        else if (a == 5'd23) m_wdat = d;
    endtask

    task automatic chk_val(input logic [4:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== e) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic chk_mdl(input logic [4:0] a, input string tag);
        chk_val(a, exp_rd(a), tag);
    endtask

    task automatic unlock();
        wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 32; i++) m_mem[b][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_val(20, 16'h0, "R1 ctrl");
        chk_val(21, 16'h0, "R1 rdat");
        chk_val(23, 16'h0, "R1 wdat");

        // R2 broken pattern keeps the banks closed
        wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0401);
        wr(23, 16'hBEEF);
        wr(20, 16'h4403);                 // R5 write while locked, ignored
        chk_val(21, 16'h0, "R2 still locked");
        unlock();
        wr(20, 16'h8460);                 // read bank0 idx3
        chk_val(21, 16'h0000, "R5 locked write had no effect");

        // R2 pattern interleaved with a non-command write still opens
        wr(20, 16'h0000); wr(20, 16'h0400); wr(22, 16'h1111);
        wr(20, 16'h0000); wr(20, 16'h0400);
        wr(23, 16'h1234);
        wr(20, 16'h4405);                 // R3 write bank0 idx5
        wr(20, 16'h84A0);                 // R4 read bank0 idx5
        chk_val(21, 16'h1234, "R3 R4 R2 bank0 idx5");
        chk_val(20, 16'h84A0, "R8 ctrl readback");

        // R9 separate banks at the same index
        wr(23, 16'h5678); wr(20, 16'h4C05);
        wr(23, 16'h9ABC); wr(20, 16'h5C05);
        wr(20, 16'h8CA0); chk_val(21, 16'h5678, "R9 bank1");
        wr(20, 16'h9CA0); chk_val(21, 16'h9ABC, "R9 bank3");
        wr(20, 16'h84A0); chk_val(21, 16'h1234, "R9 bank0");

        // R9 highest index
        wr(23, 16'hA5A5); wr(20, 16'h5C1F);
        wr(20, 16'h9FE0); chk_val(21, 16'hA5A5, "R9 bank3 idx31");

        // R7 empty bank
        wr(23, 16'hFFFF); wr(20, 16'h5405);
        wr(20, 16'h94A0); chk_val(21, 16'h0000, "R7 bank2 reads 0");
        wr(20, 16'h84A0); chk_val(21, 16'h1234, "R7 neighbours untouched");
        wr(20, 16'h8CA0); chk_val(21, 16'h5678, "R7 bank1 untouched");

        // R6 both bits set
        wr(23, 16'h0F0F);
        wr(20, 16'hC4A5);
        chk_val(21, 16'h5678, "R6 rdat unchanged");
        wr(20, 16'h84A0); chk_val(21, 16'h1234, "R6 storage unchanged");

        // R10 command without test mode relocks and is not executed
        wr(20, 16'h8CA0 & 16'hFBFF);
        chk_val(21, 16'h0000, "R10 locked");
        unlock();
        chk_val(21, 16'h1234, "R10 read not executed");

        // R5 explicit relock
        wr(20, 16'h0000);
        chk_val(21, 16'h0000, "R5 locked reads 0");
        wr(23, 16'h0000); wr(20, 16'h4405);
        unlock();
        wr(20, 16'h84A0); chk_val(21, 16'h1234, "R5 locked write ignored");

        // R8 address map
        chk_val(22, 16'h0000, "R8 unowned address");
        wr(21, 16'h7777);
        chk_val(21, 16'h1234, "R8 rdat read-only");
        wr(23, 16'h3C3C);
        chk_val(23, 16'h3C3C, "R8 wdat readback");

        // seeded random mix against the model
        seed = $urandom(32'd2024);
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            case (r)
                0: unlock();
                1: wr(20, 16'h0000);
                2: wr(23, 16'($urandom));
                3, 4: begin
                    logic [15:0] v;
                    v = 16'($urandom);
                    v[13] = 1'b0;
                    if ($urandom_range(0, 7) != 0) v[10] = 1'b1;
                    wr(20, v);
                end
                5: wr(5'($urandom), 16'($urandom));
                default: begin
                    logic [4:0] a;
                    case ($urandom_range(0, 4))
                        0: a = 5'd20;
                        1, 2: a = 5'd21;
                        3: a = 5'd23;
                        default: a = 5'($urandom);
                    endcase
                    chk_mdl(a, "R8 R3 R4 random");
                end
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule